// File: doc/BRIEF.md
# Synchronizable Programmable Clock Divider Bank

This block holds a bank of identical divider lanes that all run on one fast input clock. Each lane gives a divided clock whose ratio comes from a small fixed set that includes the non-power-of-two ratios 6 and 12. A lane can also pass the input clock straight through on its minimum-latency path. Each lane can delay its output phase by a whole number of input-clock periods, from 0 to 255.

A shared synchronization input restarts every lane at once. The delay from the sync edge to each lane's first output edge is fixed and known, so divided outputs line up within one chip and across several chips that see the same sync. Settings arrive as plain parallel configuration words, which a separate serial port keeps loaded. A lane only adopts new settings at a sync event, so rewriting a word never disturbs a running clock.

The block moves no data. It has no valid/ready interface, and every pin is a plain control or clock pin.

Top module: `sdiv_bank`

## Requirements
- R1: After reset and until the first input-clock rising edge where `sync` is sampled high, every `div_clk` bit is low.
- R2: Select code per lane (3 bits): 0 = pass-through, 1 = ÷2, 2 = ÷4, 3 = ÷6, 4 = ÷8, 5 = ÷12, 6 = ÷16, 7 = pass-through. A dividing lane repeats with a period of exactly N input cycles.
- R3: Every dividing lane has a 50% duty cycle. Each period is high for N/2 input cycles and then low for N/2, for ratios 6 and 12 as well.
- R4: Call E0 the last rising edge where `sync` was sampled high. The first output rise of a lane with delay D (8 bits, 0..255) comes exactly at rising edge E0+D+1.
- R5: A pass-through lane follows the input clock from edge E0+D+1 onward. It is low before that edge and low during the half-cycle that follows any sync-sampled edge.
- R6: From the first edge where `sync` is sampled high, and for as long as it stays high, every lane is low.
- R7: A change to a lane's select or delay word has no effect until the next sync-sampled edge. Until then the lane keeps its old ratio and phase.
- R8: Lanes that are given equal settings produce identical outputs, and every lane's phase refers to the same sync edge.
- R9: A later sync restarts every lane, and its timing from E0 is the same as after the first sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Synchronization request, sampled on the rising edge; must be stable from the preceding falling edge |
| cfg_sel | input | NCH*3 | Per-lane ratio select, lane i in bits [3i+2:3i] |
| cfg_dly | input | NCH*DLY_W | Per-lane delay in input periods, lane i in bits [8i+7:8i] |
| div_clk | output | NCH | Per-lane divided or passed-through clock |

## Verification
A dividing lane's output is a register, so its level for the edge E0+k shows up right after edge k. The bench samples it a fifth of a period after each rising edge and again after each falling edge, and expects it constant between them. A pass-through lane is combinational on the clock, so the bench expects high after each rising edge from E0+D+1 and low after each falling edge. The reference model counts rising edges since the last sync-sampled edge and holds the settings latched at that edge, so every expected value is due at a known sample point, including the full 255-cycle delay and the hold period of sync.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int SEL_W = 3;
  localparam int PH_W  = 5;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [PH_W-1:0]  ratio_t;

  function automatic ratio_t sel_to_ratio(input sel_t s);
    case (s)
      3'd1:    return ratio_t'(2);
      3'd2:    return ratio_t'(4);
      3'd3:    return ratio_t'(6);
      3'd4:    return ratio_t'(8);
      3'd5:    return ratio_t'(12);
      3'd6:    return ratio_t'(16);
      default: return ratio_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/sdiv_cfg_hold.sv
module sdiv_cfg_hold
  import sdiv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  sel_t             sel_in,
  input  logic [DLY_W-1:0] dly_in,
  output sel_t             sel_o,
  output logic [DLY_W-1:0] dly_o,
  output ratio_t           ratio_o,
  output logic             byp_o
);
  // Settings only move at a sync edge (R7)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_o   <= '0;
      dly_o   <= '0;
      ratio_o <= ratio_t'(1);
      byp_o   <= 1'b1;
    end else if (sync) begin
      sel_o   <= sel_in;
      dly_o   <= dly_in;
      ratio_o <= sel_to_ratio(sel_in);
      byp_o   <= (sel_to_ratio(sel_in) == ratio_t'(1));
    end
  end
endmodule

// File: rtl/sdiv_phase_gen.sv
module sdiv_phase_gen
  import sdiv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  ratio_t           ratio,
  input  logic [DLY_W-1:0] dly,
  input  logic             byp,
  output logic             out
);
  logic             synced, in_sync, running, out_q, live_n;
  logic [DLY_W-1:0] dcnt;
  ratio_t           pcnt;
  ratio_t           half;

  assign half = ratio >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced  <= 1'b0;
      in_sync <= 1'b0;
      running <= 1'b0;
      dcnt    <= '0;
      pcnt    <= '0;
      out_q   <= 1'b0;
    end else if (sync) begin
      synced  <= 1'b1;
      in_sync <= 1'b1;
      running <= 1'b0;
      dcnt    <= '0;
      pcnt    <= '0;
      out_q   <= 1'b0;
    end else begin
      in_sync <= 1'b0;
      if (synced && !running) begin
        if (dcnt == dly) begin
          running <= 1'b1;
          out_q   <= !byp;
          pcnt    <= (ratio == ratio_t'(1)) ? ratio_t'(0) : ratio_t'(1);
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end else if (running) begin
        out_q <= !byp && (pcnt < half);
        pcnt  <= (pcnt == ratio - 1'b1) ? ratio_t'(0) : pcnt + 1'b1;
      end
    end
  end

  // Pass-through enable, moved on the falling edge so the gate opens cleanly
  always_ff @(negedge clk) begin
    if (!rst_n) live_n <= 1'b0;
    else        live_n <= !sync && synced && (running || dcnt == dly);
  end

  assign out = byp ? (clk & live_n & !in_sync) : out_q;
endmodule

// File: rtl/sdiv_bank.sv
module sdiv_bank
  import sdiv_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DLY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync,
  input  logic [NCH*SEL_W-1:0]   cfg_sel,
  input  logic [NCH*DLY_W-1:0]   cfg_dly,
  output logic [NCH-1:0]         div_clk
);
  logic [NCH*SEL_W-1:0] act_sel_flat;
  logic [NCH*DLY_W-1:0] act_dly_flat;
  logic [NCH-1:0]       act_byp;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    ratio_t act_ratio;

    sdiv_cfg_hold #(.DLY_W(DLY_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync    (sync),
      .sel_in  (cfg_sel[i*SEL_W +: SEL_W]),
      .dly_in  (cfg_dly[i*DLY_W +: DLY_W]),
      .sel_o   (act_sel_flat[i*SEL_W +: SEL_W]),
      .dly_o   (act_dly_flat[i*DLY_W +: DLY_W]),
      .ratio_o (act_ratio),
      .byp_o   (act_byp[i])
    );

    sdiv_phase_gen #(.DLY_W(DLY_W)) u_ph (
      .clk   (clk),
      .rst_n (rst_n),
      .sync  (sync),
      .ratio (act_ratio),
      .dly   (act_dly_flat[i*DLY_W +: DLY_W]),
      .byp   (act_byp[i]),
      .out   (div_clk[i])
    );
  end
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int NCH   = 4,
  parameter int DLY_W = 8,
  parameter int SEL_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync,
  input logic [NCH-1:0]       div_clk,
  input logic [NCH*SEL_W-1:0] act_sel_flat,
  input logic [NCH*DLY_W-1:0] act_dly_flat,
  input logic [NCH-1:0]       act_byp
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n)    seen <= 1'b0;
    else if (sync) seen <= 1'b1;
  end

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> div_clk == '0); // R1

  AST_SYNC_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> div_clk == '0); // R6

  AST_CFG_MOVES_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_sel_flat, act_dly_flat}) |-> $past(sync)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_ZERO_DELAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync) && !sync && !act_byp[i] && act_dly_flat[i*DLY_W +: DLY_W] == '0)
      |=> div_clk[i]); // R4
  end
endmodule

bind sdiv_bank sdiv_checker #(.NCH(NCH), .DLY_W(DLY_W), .SEL_W(sdiv_pkg::SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync         (sync),
  .div_clk      (div_clk),
  .act_sel_flat (act_sel_flat),
  .act_dly_flat (act_dly_flat),
  .act_byp      (act_byp)
);

// File: tb/tb_sdiv_bank.sv
`timescale 1ns/1ps
module tb_sdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic [NCH*3-1:0]  cfg_sel = '0;
  logic [NCH*DW-1:0] cfg_dly = '0;
  logic [NCH-1:0]    div_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_bank #(.NCH(NCH), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .cfg_sel(cfg_sel), .cfg_dly(cfg_dly), .div_clk(div_clk)
  );

  // Reference model: edges since last sync edge and settings latched there
  bit seen;
  int k  [NCH];
  int mN [NCH];
  int mD [NCH];
  int mS [NCH];

  function automatic int ratio_of(input int s);
    case (s)
      1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      seen = 0;
      for (int i = 0; i < NCH; i++) begin k[i] = 0; mN[i] = 1; mD[i] = 0; mS[i] = 0; end
    end else if (sync) begin
      seen = 1;
      for (int i = 0; i < NCH; i++) begin
        k[i]  = 0;
        mS[i] = int'(cfg_sel[i*3 +: 3]);
        mN[i] = ratio_of(mS[i]);
        mD[i] = int'(cfg_dly[i*DW +: DW]);
      end
    end else begin
      for (int i = 0; i < NCH; i++) k[i] = k[i] + 1;
    end
  end

  function automatic bit exp_level(input int i, input bit high_phase);
    int p;
    if (!seen || k[i] == 0 || k[i] < mD[i] + 1) return 1'b0;
    if (mN[i] == 1) return high_phase;
    p = (k[i] - mD[i] - 1) % mN[i];
    return (p < mN[i] / 2);
  endfunction

  function automatic string tag_of(input int i);
    if (!seen) return "R1";
    if (k[i] == 0) return "R6";
    if (int'(cfg_sel[i*3 +: 3]) != mS[i] || int'(cfg_dly[i*DW +: DW]) != mD[i]) return "R7";
    if (k[i] < mD[i] + 1) return "R4";
    if (mN[i] == 1) return "R5";
    return "R2/R3";
  endfunction

  task automatic compare(input bit high_phase);
    for (int i = 0; i < NCH; i++) begin
      bit e;
      e = exp_level(i, high_phase);
      checks++;
      if (div_clk[i] !== e) begin
        errors++;
        $display("FAIL %s lane %0d k=%0d N=%0d D=%0d phase=%0d got %b exp %b",
                 tag_of(i), i, k[i], mN[i], mD[i], high_phase, div_clk[i], e);
      end
    end
    // R8: lanes with equal latched settings must match
    if (seen && mS[0] == mS[1] && mD[0] == mD[1]) begin
      checks++;
      if (div_clk[0] !== div_clk[1]) begin
        errors++;
        $display("FAIL R8 lanes 0/1 got %b exp %b", div_clk[1], div_clk[0]);
      end
    end
  endtask

  always begin
    @(posedge clk); #2;
    if (rst_n && !done) compare(1'b1);
    @(negedge clk); #2;
    if (rst_n && !done) compare(1'b0);
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sync(input int len);
    @(posedge clk); #1 sync = 1'b1;
    repeat (len) @(posedge clk);
    #1 sync = 1'b0;
  endtask

  task automatic set_lane(input int i, input int s, input int d);
    cfg_sel[i*3 +: 3]  = 3'(s);
    cfg_dly[i*DW +: DW] = DW'(d);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, then idle with no sync and configured lanes
    cycles(5);
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) set_lane(i, 2, 1);
    cycles(12);

    // R2 R3 R4 R5: sweep every select code across lanes and delays
    for (int s = 0; s < 8; s++) begin
      set_lane(0, s, 0);
      set_lane(1, (s + 1) % 8, 3);
      set_lane(2, (s + 3) % 8, 17);
      set_lane(3, (s + 5) % 8, s * 36);
      pulse_sync(1);
      cycles(300);
    end

    // R4 boundary: full delay of 255 on ratio 12 and pass-through; R8 equal lanes
    set_lane(0, 5, 255);
    set_lane(1, 5, 255);
    set_lane(2, 7, 255);
    set_lane(3, 3, 128);
    pulse_sync(1);
    cycles(320);

    // R6: sync held for several edges, output must stay low
    set_lane(0, 1, 0);
    set_lane(1, 0, 0);
    set_lane(2, 6, 2);
    set_lane(3, 3, 0);
    pulse_sync(6);
    cycles(60);

    // R7: rewrite settings mid-run, old behaviour continues
    set_lane(0, 6, 9);
    set_lane(1, 4, 1);
    set_lane(2, 2, 0);
    set_lane(3, 0, 44);
    cycles(80);

    // R9: resync adopts new settings with the same timing from the edge
    pulse_sync(1);
    cycles(100);
    pulse_sync(1);
    cycles(100);

    finish_run();
  end
endmodule